// File: doc/BRIEF.md
# Trigger-Started Arithmetic Function Unit

This block is an arithmetic function unit for a processor whose instructions are data moves, and in which a move into one particular port starts an operation. The unit has two input ports. The operand port only stores a value. The trigger port accepts a value together with a two-bit opcode, and that write starts the operation. The unit computes a sum, a difference or a bitwise inversion and registers the result, which then stays on the result port until a later trigger replaces it.

Each operation reads its operands from fixed ports. Addition and subtraction use both ports. Inversion has a single input, and that input is the trigger port, because only a trigger write can start work. The `SUB_SWAP` parameter picks one of two subtraction bindings. A compiled move sequence therefore gives different differences on the two variants. A value written to the operand port stays there across any number of operations. When the operand port and the trigger port are written in the same cycle, the operation uses the new operand.

Top module: `tta_alu_unit`

## Requirements
- R1: After reset `resultData` is zero and the stored operand is zero, so an addition triggered before any operand write returns the trigger value.
- R2: An operand-port write with no trigger write leaves `resultData` unchanged.
- R3: A trigger write with opcode 2'b00 puts (operand + trigger value) mod 2^DATA_W on `resultData` one clock edge later.
- R4: With `SUB_SWAP`=0, opcode 2'b01 puts (operand − trigger value) mod 2^DATA_W on `resultData` one edge after the trigger.
- R5: With `SUB_SWAP`=1, opcode 2'b01 puts (trigger value − operand) mod 2^DATA_W on `resultData` one edge after the trigger.
- R6: Opcode 2'b10 puts the bitwise inverse of the trigger value on `resultData` one edge later, whatever the stored operand is.
- R7: `resultData` keeps its value in every cycle that has no trigger write.
- R8: When the operand port and the trigger port are written in the same cycle, the triggered operation uses the newly written operand.
- R9: A trigger write with opcode 2'b11 leaves `resultData` unchanged.
- R10: The stored operand keeps its value across operations until the operand port is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opndWrEn | input | 1 | Operand-port write strobe |
| opndData | input | DATA_W | Value written to the operand port |
| trigWrEn | input | 1 | Trigger-port write strobe; starts an operation |
| trigOp | input | 2 | Opcode sent with the trigger write: 00 add, 01 subtract, 10 invert, 11 reserved |
| trigData | input | DATA_W | Value written to the trigger port |
| resultData | output | DATA_W | Registered result of the most recent valid operation |

## Verification
Every result is due on the first rising edge after the trigger write. The bench drives inputs on falling edges and reads `resultData` on the next falling edge, half a cycle after that rising edge. Operand writes go in one cycle before the trigger, except in the same-cycle test. In the hold, reserved-opcode and operand-only cases the bench reads the output one falling edge after the stimulus and compares it with the value it read before. The bench exhausts every operand/trigger pair at a 4-bit width on a default-binding instance and on a swapped-binding instance side by side, so the two subtraction results can be compared directly.

// File: rtl/tta_alu_pkg.sv
package tta_alu_pkg;

  localparam int OPC_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NOT  = 2'b10,
    OP_RSVD = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic   opndLoad;
    logic   useNewOpnd;
    logic   resLoad;
    aluOp_e op;
  } aluCtrl_t;

endpackage

// File: rtl/tta_alu_ctrl.sv
module tta_alu_ctrl
  import tta_alu_pkg::*;
(
  input  logic             opndWrEn,
  input  logic             trigWrEn,
  input  logic [OPC_W-1:0] trigOp,
  output aluCtrl_t         ctrl
);

  aluOp_e decOp;

  always_comb begin
    decOp           = aluOp_e'(trigOp);
    ctrl.opndLoad   = opndWrEn;
    ctrl.useNewOpnd = opndWrEn;
    ctrl.op         = decOp;
    case (decOp)
      OP_ADD, OP_SUB, OP_NOT: ctrl.resLoad = trigWrEn;
      default:                ctrl.resLoad = 1'b0;
    endcase
  end

endmodule

// File: rtl/tta_alu_dp.sv
module tta_alu_dp
  import tta_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit SUB_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opndData,
  input  logic [DATA_W-1:0] trigData,
  output logic [DATA_W-1:0] resultData
);

  logic [DATA_W-1:0] opndReg;
  logic [DATA_W-1:0] opndEff;
  logic [DATA_W-1:0] subMinuend;
  logic [DATA_W-1:0] subSubtrahend;
  logic [DATA_W-1:0] nextResult;
  logic [DATA_W-1:0] resultReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opndReg <= '0;
    else if (ctrl.opndLoad) opndReg <= opndData;
  end

  assign opndEff = ctrl.useNewOpnd ? opndData : opndReg;

  generate
    if (SUB_SWAP) begin : g_subSwapped
      assign subMinuend    = trigData;
      assign subSubtrahend = opndEff;
    end else begin : g_subDefault
      assign subMinuend    = opndEff;
      assign subSubtrahend = trigData;
    end
  endgenerate

  always_comb begin
    case (ctrl.op)
      OP_ADD:  nextResult = opndEff + trigData;
      OP_SUB:  nextResult = subMinuend - subSubtrahend;
      OP_NOT:  nextResult = ~trigData;
      default: nextResult = resultReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultReg <= '0;
    else if (ctrl.resLoad) resultReg <= nextResult;
  end

  assign resultData = resultReg;

endmodule

// File: rtl/tta_alu_unit.sv
module tta_alu_unit
  import tta_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit SUB_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opndWrEn,
  input  logic [DATA_W-1:0] opndData,
  input  logic              trigWrEn,
  input  logic [1:0]        trigOp,
  input  logic [DATA_W-1:0] trigData,
  output logic [DATA_W-1:0] resultData
);

  aluCtrl_t ctrl;

  tta_alu_ctrl u_ctrl (
    .opndWrEn (opndWrEn),
    .trigWrEn (trigWrEn),
    .trigOp   (trigOp),
    .ctrl     (ctrl)
  );

  tta_alu_dp #(
    .DATA_W   (DATA_W),
    .SUB_SWAP (SUB_SWAP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opndData   (opndData),
    .trigData   (trigData),
    .resultData (resultData)
  );

endmodule

// File: rtl/tta_alu_unit_checker.sv
module tta_alu_unit_checker #(
  parameter int DATA_W   = 32,
  parameter bit SUB_SWAP = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              opndWrEn,
  input logic [DATA_W-1:0] opndData,
  input logic              trigWrEn,
  input logic [1:0]        trigOp,
  input logic [DATA_W-1:0] trigData,
  input logic [DATA_W-1:0] resultData
);

  // Port-level shadow of the operand port (R10, R8)
  logic [DATA_W-1:0] shadowOpnd;
  logic [DATA_W-1:0] seenOpnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowOpnd <= '0;
    else if (opndWrEn) shadowOpnd <= opndData;
  end

  assign seenOpnd = opndWrEn ? opndData : shadowOpnd;

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !trigWrEn |=> $stable(resultData));

  a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && trigOp == 2'b11) |=> $stable(resultData));

  a_r3_add: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && trigOp == 2'b00) |=> resultData == $past(seenOpnd + trigData));

  a_r6_invert: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && trigOp == 2'b10) |=> resultData == ~$past(trigData));

  generate
    if (SUB_SWAP) begin : g_chkSwap
      a_r5_sub_swapped: assert property (@(posedge clk) disable iff (!rstN)
        (trigWrEn && trigOp == 2'b01) |=> resultData == $past(trigData - seenOpnd));
    end else begin : g_chkDefault
      a_r4_sub_default: assert property (@(posedge clk) disable iff (!rstN)
        (trigWrEn && trigOp == 2'b01) |=> resultData == $past(seenOpnd - trigData));
    end
  endgenerate

endmodule

bind tta_alu_unit tta_alu_unit_checker #(
  .DATA_W   (DATA_W),
  .SUB_SWAP (SUB_SWAP)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opndWrEn   (opndWrEn),
  .opndData   (opndData),
  .trigWrEn   (trigWrEn),
  .trigOp     (trigOp),
  .trigData   (trigData),
  .resultData (resultData)
);

// File: tb/tta_alu_unit_bench.sv
`timescale 1ns/1ps
module tta_alu_unit_bench;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opndWrEn = 1'b0;
  logic [W-1:0] opndData = '0;
  logic         trigWrEn = 1'b0;
  logic [1:0]   trigOp = 2'b00;
  logic [W-1:0] trigData = '0;
  logic [W-1:0] resA;
  logic [W-1:0] resB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tta_alu_unit #(.DATA_W(W), .SUB_SWAP(1'b0)) u_tta_alu_unit (
    .clk(clk), .rstN(rstN), .opndWrEn(opndWrEn), .opndData(opndData),
    .trigWrEn(trigWrEn), .trigOp(trigOp), .trigData(trigData), .resultData(resA));

  tta_alu_unit #(.DATA_W(W), .SUB_SWAP(1'b1)) u_tta_alu_unit_swap (
    .clk(clk), .rstN(rstN), .opndWrEn(opndWrEn), .opndData(opndData),
    .trigWrEn(trigWrEn), .trigOp(trigOp), .trigData(trigData), .resultData(resB));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    opndWrEn = 1'b0;
    trigWrEn = 1'b0;
  endtask

  task automatic putOpnd(input logic [W-1:0] v);
    @(negedge clk);
    opndWrEn = 1'b1; opndData = v; trigWrEn = 1'b0;
  endtask

  task automatic putTrig(input logic [1:0] op, input logic [W-1:0] v, input bit withOpnd,
                         input logic [W-1:0] o);
    @(negedge clk);
    opndWrEn = withOpnd; opndData = o;
    trigWrEn = 1'b1; trigOp = op; trigData = v;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] prevA, prevB;
    repeat (3) @(negedge clk);
    check("R1 reset", resA, '0);
    check("R1 reset swap", resB, '0);
    rstN = 1'b1;
    // R1: stored operand is zero, so add returns the trigger value
    putTrig(2'b00, 4'h5, 1'b0, '0);
    idle();
    check("R1 opnd zero", resA, 4'h5);

    // Exhaustive sweep: R3, R4, R5, R6
    for (int a = 0; a < SPAN; a++) begin
      for (int b = 0; b < SPAN; b++) begin
        putOpnd(W'(a));
        putTrig(2'b00, W'(b), 1'b0, '0);
        idle();
        check("R3 add", resA, W'((a + b) & MASK));
        putTrig(2'b01, W'(b), 1'b0, '0);
        idle();
        check("R4 sub default", resA, W'((a - b) & MASK));
        check("R5 sub swapped", resB, W'((b - a) & MASK));
        putTrig(2'b10, W'(b), 1'b0, '0);
        idle();
        check("R6 invert", resA, ~W'(b));
        check("R6 invert swap", resB, ~W'(b));
      end
    end

    // R2: operand-only write leaves result
    putTrig(2'b00, 4'h3, 1'b1, 4'h4);
    idle();
    prevA = resA;
    putOpnd(4'hC);
    idle();
    check("R2 opnd only", resA, prevA);

    // R7: hold over idle cycles
    repeat (5) idle();
    check("R7 hold", resA, prevA);

    // R9: reserved opcode
    prevB = resB;
    putTrig(2'b11, 4'h9, 1'b0, '0);
    idle();
    check("R9 reserved", resA, prevA);
    check("R9 reserved swap", resB, prevB);

    // R10: operand 4'hC persists across operations
    putTrig(2'b00, 4'h1, 1'b0, '0);
    idle();
    check("R10 persist 1", resA, 4'hD);
    putTrig(2'b10, 4'h0, 1'b0, '0);
    idle();
    putTrig(2'b01, 4'h2, 1'b0, '0);
    idle();
    check("R10 persist 2", resA, 4'hA);

    // R8: same-cycle write uses new operand
    for (int k = 0; k < SPAN; k++) begin
      putOpnd(4'h7);
      putTrig(2'b01, 4'h1, 1'b1, W'(k));
      idle();
      check("R8 same cycle", resA, W'((k - 1) & MASK));
      check("R8 same cycle swap", resB, W'((1 - k) & MASK));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule